// File: doc/BRIEF.md
# Adaptive Interrupt Backoff Controller

This block decides when a receive-side network interface interrupts its host. While the host keeps up, every command the interface posts for the host raises its own interrupt. The host returns a load report with each command it handles: an overload flag, or a low-load flag. The host sets the overload flag when fewer than a quarter of its 128 receive buffers are free. On the first overload report the controller switches to paced mode. In paced mode it holds back interrupts for at least a programmed minimum interval. Each further overload report stretches the interval by a backoff factor, up to a ceiling. Each low-load report shrinks the interval by a restore factor. Once the interval falls below the minimum, the controller returns to one interrupt per command.

Intervals are counted in ticks of a prescaled timebase, and the interval counter restarts at every interrupt. Both factors are unsigned Q4.8 fixed-point values: eight fraction bits, so 0x100 means 1.0. A single configuration write loads the minimum, the maximum and both factors, and also enables backoff. A separate disable pulse turns backoff off. The current interval is visible as a status output. It reads zero whenever the controller is in per-command mode.

Top module: `irq_backoff_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until configured, `irq` is 0, `cur_period` is 0 and backoff is disabled.
- R2: In per-command mode, a `cmd_new` pulse sampled at a clock edge makes `irq` high for the cycle after that edge, so back-to-back commands give back-to-back interrupt pulses.
- R3: When backoff is enabled and the controller is in per-command mode, an overload report (`load_valid`=1, `load_over`=1) enters paced mode. It sets `cur_period` to the minimum and restarts the tick count.
- R4: In paced mode each overload report sets `cur_period` to floor(period*backoff/256), saturated to the period width and then clamped to the maximum.
- R5: In paced mode each low-load report (`load_valid`=1, `load_over`=0) sets the period to floor(period*restore/256). If that value is below the minimum, the controller returns to per-command mode and `cur_period` becomes 0.
- R6: In paced mode an interrupt fires at the first edge where a command is pending and the ticks counted since the last interrupt (or since entering paced mode) are at least `cur_period`. Commands that arrive while waiting merge into that one interrupt.
- R7: No interrupt is raised while no command is pending, however long the interval has run.
- R8: `cfg_wr` loads all four parameters, enables backoff, selects per-command mode and clears `cur_period`. `cfg_dis` disables backoff, selects per-command mode and clears `cur_period`. `cfg_dis` wins when both are present, and both win over a load report in the same cycle.
- R9: While backoff is disabled, load reports have no effect.
- R10: A tick occurs every PRESCALE clock cycles, the first one in the PRESCALE-th cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_new | input | 1 | Pulse: one new command awaits the host |
| load_valid | input | 1 | Pulse: a host load report is present |
| load_over | input | 1 | Load report kind: 1 overload, 0 low load |
| cfg_wr | input | 1 | Load parameters and enable backoff |
| cfg_dis | input | 1 | Disable backoff |
| cfg_min | input | PERIOD_W | Minimum interval in ticks |
| cfg_max | input | PERIOD_W | Maximum interval in ticks |
| cfg_backoff | input | FACTOR_W | Growth factor, Q4.8, above 1.0 |
| cfg_restore | input | FACTOR_W | Decay factor, Q4.8, below 1.0 |
| irq | output | 1 | One-cycle interrupt request |
| cur_period | output | PERIOD_W | Current interval, 0 in per-command mode |

## Verification
On every cycle the assertions check the following. Per-command mode gives an immediate interrupt for each command. No interrupt fires without pending work. A paced interrupt never comes before the interval elapses. The period stays inside the minimum and maximum in paced mode and reads zero otherwise. Disable wins, disabled means per-command, and ticks keep their spacing. The exact sequence of period values under fixed-point growth, rounding down and saturation can only be shown by the bench's scenarios. The same holds for exit below the minimum and for the merge of several commands into one paced interrupt. The bench shows these through directed report chains and a long random mix compared against its cycle model.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    // Interrupt pacing mode
    typedef enum logic {
        MODE_DIRECT = 1'b0,   // one interrupt per command
        MODE_PACED  = 1'b1    // interval-paced interrupts
    } irq_mode_e;

    // Decoded effect of a host load report on the period state
    typedef enum logic [1:0] {
        EV_NONE,
        EV_ENTER,
        EV_GROW,
        EV_SHRINK
    } load_ev_e;

    // Fixed-point unit value for factors with FRAC fraction bits
    function automatic int unsigned fx_one(input int unsigned frac);
        return 32'd1 << frac;
    endfunction

endpackage

// File: rtl/irqb_tick_gen.sv
module irqb_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_every
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
            logic [CW-1:0] cnt_q;

            assign tick = (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst)       cnt_q <= '0;
                else if (tick) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/irqb_interval_timer.sv
module irqb_interval_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                restart,
    output logic [PERIOD_W-1:0] elapsed
);
    localparam logic [PERIOD_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            elapsed <= '0;
        else if (restart)
            elapsed <= '0;
        else if (tick && elapsed != TOP)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/irqb_scaler.sv
module irqb_scaler #(
    parameter int PERIOD_W = 16,
    parameter int FACTOR_W = 12,
    parameter int FRAC_W   = 8
) (
    input  logic [PERIOD_W-1:0] value,
    input  logic [FACTOR_W-1:0] factor,
    output logic [PERIOD_W-1:0] scaled
);
    localparam int PROD_W  = PERIOD_W + FACTOR_W;
    localparam int QUOT_W  = PROD_W - FRAC_W;

    logic [PROD_W-1:0] prod;
    logic [QUOT_W-1:0] quot;

    assign prod = PROD_W'(value) * PROD_W'(factor);
    // dropping the fraction bits rounds toward zero
    assign quot = prod[PROD_W-1:FRAC_W];

    generate
        if (QUOT_W > PERIOD_W) begin : g_sat
            logic ovf;
            assign ovf    = |quot[QUOT_W-1:PERIOD_W];
            assign scaled = ovf ? {PERIOD_W{1'b1}} : quot[PERIOD_W-1:0];
        end else begin : g_fit
            assign scaled = PERIOD_W'(quot);
        end
    endgenerate
endmodule

// File: rtl/irq_backoff_ctrl.sv
module irq_backoff_ctrl
    import irqb_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int FACTOR_W = 12,
    parameter int FRAC_W   = 8,
    parameter int PRESCALE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_new,
    input  logic                load_valid,
    input  logic                load_over,
    input  logic                cfg_wr,
    input  logic                cfg_dis,
    input  logic [PERIOD_W-1:0] cfg_min,
    input  logic [PERIOD_W-1:0] cfg_max,
    input  logic [FACTOR_W-1:0] cfg_backoff,
    input  logic [FACTOR_W-1:0] cfg_restore,
    output logic                irq,
    output logic [PERIOD_W-1:0] cur_period
);
    // configuration state
    logic                en_q;
    logic [PERIOD_W-1:0] min_q, max_q;
    logic [FACTOR_W-1:0] bf_q, rf_q;

    // pacing state
    irq_mode_e           mode_q;
    logic [PERIOD_W-1:0] period_q;
    logic                pend_q;
    logic                irq_q;

    logic                tick;
    logic [PERIOD_W-1:0] elapsed;
    logic [PERIOD_W-1:0] grown_raw, grown, shrunk;
    logic                paced, pend_any, due, fire, enter;
    load_ev_e            ev;

    irqb_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    irqb_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (fire | enter),
        .elapsed (elapsed)
    );

    irqb_scaler #(.PERIOD_W(PERIOD_W), .FACTOR_W(FACTOR_W), .FRAC_W(FRAC_W)) u_grow (
        .value  (period_q),
        .factor (bf_q),
        .scaled (grown_raw)
    );

    irqb_scaler #(.PERIOD_W(PERIOD_W), .FACTOR_W(FACTOR_W), .FRAC_W(FRAC_W)) u_shrink (
        .value  (period_q),
        .factor (rf_q),
        .scaled (shrunk)
    );

    assign grown = (grown_raw > max_q) ? max_q : grown_raw;

    // interrupt decision from the state before the edge
    assign paced    = (mode_q == MODE_PACED);
    assign pend_any = pend_q | cmd_new;
    assign due      = (elapsed >= period_q);
    assign fire     = pend_any && (!paced || due);

    // load report decode; configuration pulses take precedence
    always_comb begin
        ev = EV_NONE;
        if (en_q && load_valid && !cfg_wr && !cfg_dis) begin
            if (load_over)
                ev = paced ? EV_GROW : EV_ENTER;
            else if (paced)
                ev = EV_SHRINK;
        end
    end

    assign enter = (ev == EV_ENTER);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            min_q    <= '0;
            max_q    <= '0;
            bf_q     <= '0;
            rf_q     <= '0;
            mode_q   <= MODE_DIRECT;
            period_q <= '0;
            pend_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q  <= fire;
            pend_q <= pend_any & ~fire;
            if (cfg_dis) begin
                en_q     <= 1'b0;
                mode_q   <= MODE_DIRECT;
                period_q <= '0;
            end else if (cfg_wr) begin
                en_q     <= 1'b1;
                min_q    <= cfg_min;
                max_q    <= cfg_max;
                bf_q     <= cfg_backoff;
                rf_q     <= cfg_restore;
                mode_q   <= MODE_DIRECT;
                period_q <= '0;
            end else begin
                case (ev)
                    EV_ENTER: begin
                        mode_q   <= MODE_PACED;
                        period_q <= min_q;
                    end
                    EV_GROW: period_q <= grown;
                    EV_SHRINK: begin
                        if (shrunk < min_q) begin
                            mode_q   <= MODE_DIRECT;
                            period_q <= '0;
                        end else begin
                            period_q <= shrunk;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign irq        = irq_q;
    assign cur_period = period_q;
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
    parameter int PERIOD_W = 16,
    parameter int PRESCALE = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_new,
    input logic                cfg_dis,
    input logic                irq,
    input logic [PERIOD_W-1:0] cur_period,
    input logic                paced,
    input logic                en,
    input logic                pend,
    input logic                tick,
    input logic [PERIOD_W-1:0] elapsed,
    input logic [PERIOD_W-1:0] min_q,
    input logic [PERIOD_W-1:0] max_q
);
    int unsigned since_tick;

    always_ff @(posedge clk) begin
        if (rst)       since_tick <= 0;
        else if (tick) since_tick <= 0;
        else           since_tick <= since_tick + 1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!irq && cur_period == '0));

    a_r2_direct_each_cmd: assert property (@(posedge clk) disable iff (rst)
        (!paced && cmd_new) |=> irq);

    a_r7_irq_needs_work: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pend || cmd_new));

    a_r6_not_before_period: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(paced)) |-> $past(elapsed >= cur_period));

    a_r4_period_window: assert property (@(posedge clk) disable iff (rst)
        paced |-> (cur_period >= min_q && cur_period <= max_q));

    a_r5_direct_zero: assert property (@(posedge clk) disable iff (rst)
        !paced |-> (cur_period == '0));

    a_r9_disabled_direct: assert property (@(posedge clk) disable iff (rst)
        !en |-> !paced);

    a_r8_disable_wins: assert property (@(posedge clk) disable iff (rst)
        cfg_dis |=> (!en && !paced));

    a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |-> (since_tick == PRESCALE - 1));

    a_r10_tick_bound: assert property (@(posedge clk) disable iff (rst)
        since_tick < PRESCALE);
endmodule

bind irq_backoff_ctrl irqb_checker #(
    .PERIOD_W (PERIOD_W),
    .PRESCALE (PRESCALE)
) u_irqb_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_new    (cmd_new),
    .cfg_dis    (cfg_dis),
    .irq        (irq),
    .cur_period (cur_period),
    .paced      (paced),
    .en         (en_q),
    .pend       (pend_q),
    .tick       (tick),
    .elapsed    (elapsed),
    .min_q      (min_q),
    .max_q      (max_q)
);

// File: tb/irq_backoff_ctrl_bench.sv
module irq_backoff_ctrl_bench;
    localparam int PW  = 16;
    localparam int FW  = 12;
    localparam int PRE = 4;
    localparam int PMAX = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_new = 1'b0, load_valid = 1'b0, load_over = 1'b0;
    logic          cfg_wr = 1'b0, cfg_dis = 1'b0;
    logic [PW-1:0] cfg_min = '0, cfg_max = '0;
    logic [FW-1:0] cfg_backoff = '0, cfg_restore = '0;
    logic          irq;
    logic [PW-1:0] cur_period;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_backoff_ctrl #(.PERIOD_W(PW), .FACTOR_W(FW), .FRAC_W(8), .PRESCALE(PRE)) u_irq_backoff_ctrl (
        .clk(clk), .rst(rst), .cmd_new(cmd_new), .load_valid(load_valid),
        .load_over(load_over), .cfg_wr(cfg_wr), .cfg_dis(cfg_dis),
        .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_backoff(cfg_backoff),
        .cfg_restore(cfg_restore), .irq(irq), .cur_period(cur_period)
    );

    // ---------------- reference model from the requirements ----------------
    bit m_en, m_back, m_pend, m_irq;
    int m_per, m_el, m_pc, m_min, m_max, m_bf, m_rf;

    function automatic int f_grow(input int p, input int bf, input int mx);
        longint x;
        x = (longint'(p) * longint'(bf)) >>> 8;    // R4 floor
        if (x > PMAX) x = PMAX;                      // R4 saturate
        if (x > mx)   x = mx;                        // R4 clamp
        return int'(x);
    endfunction

    function automatic int f_shrink(input int p, input int rf);
        longint x;
        x = (longint'(p) * longint'(rf)) >>> 8;    // R5 floor
        if (x > PMAX) x = PMAX;
        return int'(x);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_back = 0; m_pend = 0; m_irq = 0;
            m_per = 0; m_el = 0; m_pc = 0;
            m_min = 0; m_max = 0; m_bf = 0; m_rf = 0;
        end else begin
            bit pany, fire, tk, ent;
            int s;
            pany = m_pend | cmd_new;
            fire = m_back ? (pany && m_el >= m_per) : pany;   // R2, R6, R7
            tk   = (m_pc == PRE - 1);                          // R10
            m_pc = tk ? 0 : m_pc + 1;
            ent  = 0;
            if (cfg_dis) begin                                 // R8
                m_en = 0; m_back = 0; m_per = 0;
            end else if (cfg_wr) begin
                m_en = 1; m_back = 0; m_per = 0;
                m_min = cfg_min; m_max = cfg_max; m_bf = cfg_backoff; m_rf = cfg_restore;
            end else if (m_en && load_valid) begin             // R9 when disabled
                if (load_over) begin
                    if (!m_back) begin m_back = 1; m_per = m_min; ent = 1; end   // R3
                    else m_per = f_grow(m_per, m_bf, m_max);                       // R4
                end else if (m_back) begin
                    s = f_shrink(m_per, m_rf);                                     // R5
                    if (s < m_min) begin m_back = 0; m_per = 0; end
                    else m_per = s;
                end
            end
            if (fire || ent)             m_el = 0;
            else if (tk && m_el != PMAX) m_el = m_el + 1;
            m_pend = pany & ~fire;
            m_irq  = fire;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // continuous comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(m_back ? "R6 irq paced" : "R2 irq direct", int'(irq), int'(m_irq));
            chk("R4 cur_period", int'(cur_period), m_per);
        end
    end

    // ---------------- stimulus ----------------
    task automatic configure(input int mn, input int mx, input int bf, input int rf);
        @(negedge clk);
        cfg_wr = 1; cfg_min = PW'(mn); cfg_max = PW'(mx);
        cfg_backoff = FW'(bf); cfg_restore = FW'(rf);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic report(input bit over);
        @(negedge clk);
        load_valid = 1; load_over = over;
        @(negedge clk);
        load_valid = 0;
    endtask

    task automatic command();
        @(negedge clk);
        cmd_new = 1;
        @(negedge clk);
        cmd_new = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nirq;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 period in reset", int'(cur_period), 0);
        rst = 0;

        // R9: reports ignored while disabled
        report(1'b1);
        chk("R9 disabled overload", int'(cur_period), 0);
        // R2: per-command interrupt in the next cycle
        command();
        chk("R2 irq after cmd", int'(irq), 1);
        @(negedge clk);
        chk("R2 single pulse", int'(irq), 0);

        // R3/R4/R5 chain: min 10, max 100, x2.0, x0.5
        configure(10, 100, 'h200, 'h080);
        report(1'b1);
        chk("R3 enter at min", int'(cur_period), 10);
        command();
        chk("R3 no early irq", int'(irq), 0);
        report(1'b1); chk("R4 grow 20", int'(cur_period), 20);
        report(1'b1); chk("R4 grow 40", int'(cur_period), 40);
        report(1'b1); chk("R4 grow 80", int'(cur_period), 80);
        report(1'b1); chk("R4 clamp 100", int'(cur_period), 100);
        report(1'b1); chk("R4 stay 100", int'(cur_period), 100);
        report(1'b0); chk("R5 shrink 50", int'(cur_period), 50);
        report(1'b0); chk("R5 shrink 25", int'(cur_period), 25);
        report(1'b0); chk("R5 shrink 12", int'(cur_period), 12);
        report(1'b0); chk("R5 exit below min", int'(cur_period), 0);

        // rounding: min 5, x1.5, x0.75
        configure(5, 1000, 'h180, 'h0C0);
        report(1'b1); chk("R3 enter 5", int'(cur_period), 5);
        report(1'b1); chk("R4 floor 7", int'(cur_period), 7);
        report(1'b0); chk("R5 floor 5", int'(cur_period), 5);
        report(1'b0); chk("R5 exit 3<5", int'(cur_period), 0);

        // saturation at the period width
        configure(1, PMAX, 'hFFF, 'h080);
        report(1'b1);
        repeat (5) report(1'b1);
        chk("R4 saturate", int'(cur_period), PMAX);

        // R7: no interrupt without pending work, then immediate when due
        configure(2, 50, 'h200, 'h080);
        report(1'b1);
        nirq = 0;
        repeat (100) begin
            @(negedge clk);
            if (irq) nirq++;
        end
        chk("R7 idle no irq", nirq, 0);
        command();
        chk("R6 due irq", int'(irq), 1);

        // R8: disable wins over a simultaneous configure
        @(negedge clk);
        cfg_wr = 1; cfg_dis = 1; cfg_min = 8;
        @(negedge clk);
        cfg_wr = 0; cfg_dis = 0;
        report(1'b1);
        chk("R8 disable wins", int'(cur_period), 0);
        configure(8, 64, 'h200, 'h080);
        report(1'b1);
        chk("R8 reenabled min", int'(cur_period), 8);

        // random mix compared against the model
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            cmd_new    = ($urandom_range(3) == 0);
            load_valid = ($urandom_range(7) == 0);
            load_over  = ($urandom_range(1) == 0);
            cfg_dis    = ($urandom_range(3000) == 0);
            cfg_wr     = ($urandom_range(1500) == 0);
            if (cfg_wr) begin
                int mn;
                mn = $urandom_range(20, 1);
                cfg_min = PW'(mn);
                cfg_max = PW'(mn + $urandom_range(200));
                cfg_backoff = FW'($urandom_range('h400, 'h101));
                cfg_restore = FW'($urandom_range('hFF, 'h20));
            end
        end
        @(negedge clk);
        cmd_new = 0; load_valid = 0; cfg_wr = 0; cfg_dis = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule